// File: doc/BRIEF.md
# Virtual Instruction Tag Matcher

This block decides whether one stored instruction-cache tag entry serves the current fetch. The fetch supplies its virtual address, the current address space number, the current privilege mode and a flag that shows whether fetching uses physical addressing. The entry supplies the upper virtual tag bits, an address space number, a global-match flag, a physical-mode marker, a valid bit, one permission bit per privilege mode and a parity bit. The matcher returns three flags one cycle later: hit, access violation and parity error.

A second path prepares entries for storage. A write request carries the entry fields without parity. One cycle later the block presents the same fields with an even-parity bit added. The cache array beside the block can store that result directly. Way selection, the data array and the predecode bits belong to neighbouring logic.

Top module: `vtag_matcher`

## Requirements
- R1: A lookup hits when the entry is valid, its tag equals fetch address bits 47..15, its physical-mode marker equals the fetch physical flag, the entry's address space number equals the current one, and the parity is correct. Fetch address bits 14..0 have no effect on the result.
- R2: When the entry's global-match flag is 1, the address space numbers are not compared. When the flag is 0, unequal address space numbers give a miss.
- R3: When the entry's physical-mode marker differs from the fetch physical flag, the lookup misses, in both directions of the mismatch.
- R4: An entry with valid = 0 gives hit = 0, access violation = 0 and parity error = 0, whatever its other fields and its parity bit hold.
- R5: Access violation is 1 only on a hit whose permission bit is 0. The permission bit is bit m of the 4-bit permission field, where m is the 2-bit mode: 0 kernel, 1 executive, 2 supervisor, 3 user. The other permission bits have no effect.
- R6: On a valid entry, the parity error flag is 1 when the XOR of the tag, address space number, global flag, physical marker, the four permission bits and the stored parity bit is 1. Parity error forces hit and access violation to 0. This holds whether or not the tag matches.
- R7: In the cycle after a write request, the write outputs carry the requested valid, tag, address space number, global flag, physical marker and permission fields. They also carry a parity bit that makes the XOR of the covered fields and that bit equal 0.
- R8: While no write request is present, the write outputs hold their values, even when the write field inputs change.
- R9: While reset is asserted, and in the first sample after it, all outputs are 0.
- R10: Lookup results appear one clock after the lookup inputs and reflect only the inputs of that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 48 | Fetch virtual address |
| lk_asn | input | 8 | Current address space number |
| lk_mode | input | 2 | Current privilege mode (0 kernel, 1 executive, 2 supervisor, 3 user) |
| lk_phys | input | 1 | Fetch uses physical addressing |
| ent_valid | input | 1 | Stored entry valid |
| ent_tag | input | 33 | Stored virtual tag (address bits 47..15) |
| ent_asn | input | 8 | Stored address space number |
| ent_glob | input | 1 | Stored global-match flag |
| ent_phys | input | 1 | Stored physical-mode marker |
| ent_perm | input | 4 | Stored permission bits, indexed by mode |
| ent_par | input | 1 | Stored parity bit |
| hit | output | 1 | Lookup hit |
| acc_viol | output | 1 | Hit without permission for the current mode |
| par_err | output | 1 | Valid entry with a parity mismatch |
| wr_en | input | 1 | Write request |
| wr_valid | input | 1 | Valid bit to store |
| wr_tag | input | 33 | Tag to store |
| wr_asn | input | 8 | Address space number to store |
| wr_glob | input | 1 | Global flag to store |
| wr_phys | input | 1 | Physical marker to store |
| wr_perm | input | 4 | Permission bits to store |
| q_valid | output | 1 | Prepared valid bit |
| q_tag | output | 33 | Prepared tag |
| q_asn | output | 8 | Prepared address space number |
| q_glob | output | 1 | Prepared global flag |
| q_phys | output | 1 | Prepared physical marker |
| q_perm | output | 4 | Prepared permission bits |
| q_par | output | 1 | Computed even-parity bit |

## Verification
The lookup path holds only one register stage, so a wrong decision shows at hit, access violation or parity error in the very next cycle. The bench therefore compares every cycle. A wrong mode decode or wrong parity coverage shows only for particular field patterns. The directed steps clear each permission bit in turn, flip the parity bit and flip a single tag bit, and a long random run then mixes these cases. A wrong value in the prepared-entry register stays at the write outputs until the next write, so a bad capture or hold is seen in the first cycle after it occurs.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

   // Privilege mode encoding used to index the permission field
   typedef enum logic [1:0] {
      MODE_KERNEL = 2'd0,
      MODE_EXEC   = 2'd1,
      MODE_SUPER  = 2'd2,
      MODE_USER   = 2'd3
   } priv_mode_e;

   localparam int unsigned DEF_VA_W      = 48;
   localparam int unsigned DEF_TAG_LO    = 15;
   localparam int unsigned DEF_ASN_W     = 8;
   localparam int unsigned DEF_NUM_MODES = 4;

   // Number of bits a parity word covers for a given geometry
   function automatic int unsigned par_cover_w(int unsigned tag_w,
                                               int unsigned asn_w,
                                               int unsigned modes);
      return tag_w + asn_w + 2 + modes;
   endfunction

endpackage

// File: rtl/vtag_parity.sv
module vtag_parity #(
   parameter int unsigned W        = 8,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [W-1:0] din,
   output logic         odd
);

   if (W < 1) begin : g_bad_w
      $error("vtag_parity: W must be at least 1");
   end

   if (USE_TREE) begin : g_tree
      localparam int unsigned LV = (W > 1) ? $clog2(W) : 1;
      localparam int unsigned P  = 1 << LV;

      // Balanced XOR tree, one vector per level
      for (genvar l = 0; l <= LV; l++) begin : g_lv
         logic [(P >> l)-1:0] v;
         if (l == 0) begin : g_leaf
            assign v = P'(din);
         end else begin : g_node
            for (genvar j = 0; j < (P >> l); j++) begin : g_x
               assign v[j] = g_lv[l-1].v[2*j] ^ g_lv[l-1].v[2*j+1];
            end
         end
      end
      assign odd = g_lv[LV].v[0];
   end else begin : g_flat
      assign odd = ^din;
   end

endmodule

// File: rtl/vtag_compare.sv
module vtag_compare #(
   parameter int unsigned TAG_W     = 33,
   parameter int unsigned ASN_W     = 8,
   parameter int unsigned NUM_MODES = 4,
   localparam int unsigned MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
   input  logic [TAG_W-1:0]     va_tag,
   input  logic [ASN_W-1:0]     cur_asn,
   input  logic [MODE_W-1:0]    cur_mode,
   input  logic                 cur_phys,
   input  logic                 e_valid,
   input  logic [TAG_W-1:0]     e_tag,
   input  logic [ASN_W-1:0]     e_asn,
   input  logic                 e_glob,
   input  logic                 e_phys,
   input  logic [NUM_MODES-1:0] e_perm,
   input  logic                 par_bad,
   output logic                 hit,
   output logic                 viol,
   output logic                 perr
);

   if (NUM_MODES != (1 << MODE_W)) begin : g_bad_modes
      $error("vtag_compare: NUM_MODES must be a power of two");
   end

   logic tag_eq, asn_ok, phys_eq, match;
   logic [NUM_MODES-1:0] mode_dec;
   logic perm_ok;

   assign tag_eq  = (va_tag == e_tag);
   assign asn_ok  = e_glob | (cur_asn == e_asn);
   assign phys_eq = ~(cur_phys ^ e_phys);

   // One-hot mode decode, then pick the permission bit
   for (genvar m = 0; m < NUM_MODES; m++) begin : g_dec
      assign mode_dec[m] = (cur_mode == MODE_W'(m));
   end
   assign perm_ok = |(mode_dec & e_perm);

   assign match = e_valid & tag_eq & asn_ok & phys_eq;
   assign perr  = e_valid & par_bad;
   assign hit   = match & ~perr;
   assign viol  = hit & ~perm_ok;

endmodule

// File: rtl/vtag_wrport.sv
module vtag_wrport #(
   parameter int unsigned TAG_W     = 33,
   parameter int unsigned ASN_W     = 8,
   parameter int unsigned NUM_MODES = 4,
   parameter bit          PAR_TREE  = 1'b1,
   localparam int unsigned COV_W    = TAG_W + ASN_W + 2 + NUM_MODES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_valid,
   input  logic [TAG_W-1:0]     wr_tag,
   input  logic [ASN_W-1:0]     wr_asn,
   input  logic                 wr_glob,
   input  logic                 wr_phys,
   input  logic [NUM_MODES-1:0] wr_perm,
   output logic                 q_valid,
   output logic [TAG_W-1:0]     q_tag,
   output logic [ASN_W-1:0]     q_asn,
   output logic                 q_glob,
   output logic                 q_phys,
   output logic [NUM_MODES-1:0] q_perm,
   output logic                 q_par
);

   logic new_par;

   vtag_parity #(.W(COV_W), .USE_TREE(PAR_TREE)) u_gen (
      .din ({wr_tag, wr_asn, wr_glob, wr_phys, wr_perm}),
      .odd (new_par)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_tag   <= '0;
         q_asn   <= '0;
         q_glob  <= 1'b0;
         q_phys  <= 1'b0;
         q_perm  <= '0;
         q_par   <= 1'b0;
      end else if (wr_en) begin
         q_valid <= wr_valid;
         q_tag   <= wr_tag;
         q_asn   <= wr_asn;
         q_glob  <= wr_glob;
         q_phys  <= wr_phys;
         q_perm  <= wr_perm;
         q_par   <= new_par;
      end
   end

   // R7: prepared word always carries even parity after a write
   assert_wr_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> ((^{q_tag, q_asn, q_glob, q_phys, q_perm, q_par}) == 1'b0));

   // R8: no request, no change
   assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> ($stable(q_tag) && $stable(q_asn) && $stable(q_perm)
                         && $stable(q_par) && $stable(q_valid)));

endmodule

// File: rtl/vtag_matcher.sv
module vtag_matcher #(
   parameter int unsigned VA_W      = vtag_pkg::DEF_VA_W,
   parameter int unsigned TAG_LO    = vtag_pkg::DEF_TAG_LO,
   parameter int unsigned ASN_W     = vtag_pkg::DEF_ASN_W,
   parameter int unsigned NUM_MODES = vtag_pkg::DEF_NUM_MODES,
   parameter bit          PAR_TREE  = 1'b1,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [VA_W-1:0]              lk_vaddr,
   input  logic [ASN_W-1:0]             lk_asn,
   input  logic [$clog2(NUM_MODES)-1:0] lk_mode,
   input  logic                         lk_phys,
   input  logic                         ent_valid,
   input  logic [VA_W-TAG_LO-1:0]       ent_tag,
   input  logic [ASN_W-1:0]             ent_asn,
   input  logic                         ent_glob,
   input  logic                         ent_phys,
   input  logic [NUM_MODES-1:0]         ent_perm,
   input  logic                         ent_par,
   output logic                         hit,
   output logic                         acc_viol,
   output logic                         par_err,
   input  logic                         wr_en,
   input  logic                         wr_valid,
   input  logic [VA_W-TAG_LO-1:0]       wr_tag,
   input  logic [ASN_W-1:0]             wr_asn,
   input  logic                         wr_glob,
   input  logic                         wr_phys,
   input  logic [NUM_MODES-1:0]         wr_perm,
   output logic                         q_valid,
   output logic [VA_W-TAG_LO-1:0]       q_tag,
   output logic [ASN_W-1:0]             q_asn,
   output logic                         q_glob,
   output logic                         q_phys,
   output logic [NUM_MODES-1:0]         q_perm,
   output logic                         q_par
);

   localparam int unsigned TAG_W = VA_W - TAG_LO;
   localparam int unsigned COV_W = vtag_pkg::par_cover_w(TAG_W, ASN_W, NUM_MODES);

   if (TAG_LO >= VA_W) begin : g_bad_tag
      $error("vtag_matcher: TAG_LO must be below VA_W");
   end
   if (NUM_MODES < 2) begin : g_bad_modes
      $error("vtag_matcher: at least two privilege modes needed");
   end

   logic par_odd;
   logic hit_c, viol_c, perr_c;

   // Check word: covered fields plus stored parity, even overall when intact
   vtag_parity #(.W(COV_W + 1), .USE_TREE(PAR_TREE)) u_chk (
      .din ({ent_tag, ent_asn, ent_glob, ent_phys, ent_perm, ent_par}),
      .odd (par_odd)
   );

   vtag_compare #(.TAG_W(TAG_W), .ASN_W(ASN_W), .NUM_MODES(NUM_MODES)) u_cmp (
      .va_tag   (lk_vaddr[VA_W-1:TAG_LO]),
      .cur_asn  (lk_asn),
      .cur_mode (lk_mode),
      .cur_phys (lk_phys),
      .e_valid  (ent_valid),
      .e_tag    (ent_tag),
      .e_asn    (ent_asn),
      .e_glob   (ent_glob),
      .e_phys   (ent_phys),
      .e_perm   (ent_perm),
      .par_bad  (par_odd),
      .hit      (hit_c),
      .viol     (viol_c),
      .perr     (perr_c)
   );

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hit      <= 1'b0;
            acc_viol <= 1'b0;
            par_err  <= 1'b0;
         end else begin
            hit      <= hit_c;
            acc_viol <= viol_c;
            par_err  <= perr_c;
         end
      end
   end else begin : g_ocomb
      assign hit      = hit_c & rst_n;
      assign acc_viol = viol_c & rst_n;
      assign par_err  = perr_c & rst_n;
   end

   vtag_wrport #(
      .TAG_W(TAG_W), .ASN_W(ASN_W), .NUM_MODES(NUM_MODES), .PAR_TREE(PAR_TREE)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_valid (wr_valid),
      .wr_tag   (wr_tag),
      .wr_asn   (wr_asn),
      .wr_glob  (wr_glob),
      .wr_phys  (wr_phys),
      .wr_perm  (wr_perm),
      .q_valid  (q_valid),
      .q_tag    (q_tag),
      .q_asn    (q_asn),
      .q_glob   (q_glob),
      .q_phys   (q_phys),
      .q_perm   (q_perm),
      .q_par    (q_par)
   );

   // R4: an invalid entry never produces a hit or a parity error
   assert_invalid_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_valid |-> (!hit_c && !perr_c && !viol_c));

   // R3: physical-mode mismatch always misses
   assert_phys_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_phys != lk_phys) |-> !hit_c);

   // R5: violation only accompanies a hit
   assert_viol_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_viol |-> hit);

   // R6: a parity error suppresses the hit and the violation
   assert_perr_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |-> (!hit && !acc_viol));

endmodule

// File: tb/tb_vtag_matcher.sv
module tb_vtag_matcher;
   import vtag_pkg::*;

   logic clk = 1'b0;
   logic rst_n;
   logic [47:0] lk_vaddr;
   logic [7:0]  lk_asn;
   logic [1:0]  lk_mode;
   logic        lk_phys;
   logic        ent_valid, ent_glob, ent_phys, ent_par;
   logic [32:0] ent_tag;
   logic [7:0]  ent_asn;
   logic [3:0]  ent_perm;
   logic        hit, acc_viol, par_err;
   logic        wr_en, wr_valid, wr_glob, wr_phys;
   logic [32:0] wr_tag;
   logic [7:0]  wr_asn;
   logic [3:0]  wr_perm;
   logic        q_valid, q_glob, q_phys, q_par;
   logic [32:0] q_tag;
   logic [7:0]  q_asn;
   logic [3:0]  q_perm;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model of the prepared-entry register
   logic [49:0] qm;  // {valid, tag, asn, glob, phys, perm, par}

   always #4 clk = ~clk;

   vtag_matcher dut (
      .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_asn(lk_asn),
      .lk_mode(lk_mode), .lk_phys(lk_phys), .ent_valid(ent_valid),
      .ent_tag(ent_tag), .ent_asn(ent_asn), .ent_glob(ent_glob),
      .ent_phys(ent_phys), .ent_perm(ent_perm), .ent_par(ent_par),
      .hit(hit), .acc_viol(acc_viol), .par_err(par_err),
      .wr_en(wr_en), .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_asn(wr_asn),
      .wr_glob(wr_glob), .wr_phys(wr_phys), .wr_perm(wr_perm),
      .q_valid(q_valid), .q_tag(q_tag), .q_asn(q_asn), .q_glob(q_glob),
      .q_phys(q_phys), .q_perm(q_perm), .q_par(q_par)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic even_bit(logic [32:0] t, logic [7:0] a, logic g,
                                     logic p, logic [3:0] pm);
      return ^{t, a, g, p, pm};
   endfunction

   task automatic fix_par();
      ent_par = even_bit(ent_tag, ent_asn, ent_glob, ent_phys, ent_perm);
   endtask

   // entry matching the current lookup, full permission, good parity
   task automatic good_entry();
      ent_valid = 1'b1;
      ent_tag   = lk_vaddr[47:15];
      ent_asn   = lk_asn;
      ent_glob  = 1'b0;
      ent_phys  = lk_phys;
      ent_perm  = 4'hF;
      fix_par();
   endtask

   // one clock: predict from present inputs, then sample at next negedge
   task automatic cyc(string req);
      logic e_match, e_perr, e_hit, e_viol;
      e_perr  = ent_valid && ((^{ent_tag, ent_asn, ent_glob, ent_phys, ent_perm, ent_par}) == 1'b1);
      e_match = ent_valid && (ent_tag == lk_vaddr[47:15]) && (ent_phys == lk_phys)
                && (ent_glob || (ent_asn == lk_asn));
      e_hit   = e_match && !e_perr;
      e_viol  = e_hit && !ent_perm[lk_mode];
      if (wr_en && rst_n)
         qm = {wr_valid, wr_tag, wr_asn, wr_glob, wr_phys, wr_perm,
               even_bit(wr_tag, wr_asn, wr_glob, wr_phys, wr_perm)};
      if (!rst_n) begin
         qm = '0; e_hit = 0; e_viol = 0; e_perr = 0;
      end
      @(posedge clk);
      @(negedge clk);
      chk(req, "hit", 64'(hit), 64'(e_hit));
      chk(req, "acc_viol", 64'(acc_viol), 64'(e_viol));
      chk(req, "par_err", 64'(par_err), 64'(e_perr));
      chk(req, "q_word",
          64'({q_valid, q_tag, q_asn, q_glob, q_phys, q_perm, q_par}), 64'(qm));
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      lk_vaddr = 48'h1234_5678_9ABC; lk_asn = 8'h5A; lk_mode = MODE_KERNEL; lk_phys = 1'b0;
      good_entry();
      wr_en = 1'b0; wr_valid = 1'b0; wr_tag = '0; wr_asn = '0;
      wr_glob = 1'b0; wr_phys = 1'b0; wr_perm = '0;
      qm = '0;
      // R9: reset holds everything low although the entry would hit
      for (int i = 0; i < 3; i++) cyc("R9");
      rst_n = 1'b1;
      lk_vaddr = 48'h0;
      good_entry();
      ent_valid = 1'b0;
      cyc("R9");

      // R1: basic hit, then low address bits vary
      lk_vaddr = 48'hABCD_EF01_2345; good_entry(); cyc("R1");
      lk_vaddr[14:0] = 15'h7FFF; cyc("R1");
      lk_vaddr[14:0] = 15'h0000; cyc("R1");
      // R1: single tag bit differs at each end
      lk_vaddr[15] = ~lk_vaddr[15]; cyc("R1");
      lk_vaddr[15] = ~lk_vaddr[15]; lk_vaddr[47] = ~lk_vaddr[47]; cyc("R1");
      lk_vaddr[47] = ~lk_vaddr[47];

      // R2: address space number mismatch with and without global flag
      good_entry(); lk_asn = lk_asn ^ 8'h80; cyc("R2");
      ent_glob = 1'b1; fix_par(); cyc("R2");
      lk_asn = lk_asn ^ 8'h01; cyc("R2");

      // R3: physical marker mismatch both ways
      good_entry(); ent_phys = 1'b1; lk_phys = 1'b0; fix_par(); cyc("R3");
      ent_phys = 1'b0; lk_phys = 1'b1; fix_par(); cyc("R3");
      ent_phys = 1'b1; fix_par(); cyc("R3");
      lk_phys = 1'b0;

      // R4: invalid entry with bad parity stays silent
      good_entry(); ent_valid = 1'b0; ent_par = ~ent_par; cyc("R4");
      ent_perm = 4'h0; cyc("R4");

      // R5: each mode against its own and other permission bits
      for (int m = 0; m < 4; m++) begin
         good_entry(); lk_mode = 2'(m);
         ent_perm = ~(4'b1 << m); fix_par(); cyc("R5");
         ent_perm = 4'b1 << m; fix_par(); cyc("R5");
      end
      lk_mode = MODE_USER; good_entry(); ent_perm = 4'h0; fix_par();
      lk_asn = lk_asn + 8'd1; cyc("R5");  // miss: no violation
      lk_asn = lk_asn - 8'd1;

      // R6: parity flip on matching and non-matching entries
      good_entry(); ent_par = ~ent_par; cyc("R6");
      ent_perm = 4'h0; cyc("R6");
      ent_tag = ent_tag ^ 33'h1; cyc("R6");

      // R10: hit for one cycle then miss in the next
      good_entry(); cyc("R10");
      ent_valid = 1'b0; cyc("R10");

      // R7: writes produce fields plus even parity
      wr_en = 1'b1; wr_valid = 1'b1; wr_tag = 33'h1_5555_AAAA; wr_asn = 8'hC3;
      wr_glob = 1'b1; wr_phys = 1'b0; wr_perm = 4'b1010; cyc("R7");
      wr_tag = 33'h0_0000_0001; wr_asn = 8'h00; wr_glob = 1'b0; wr_perm = 4'h0; cyc("R7");
      // R8: fields move but no request
      wr_en = 1'b0; wr_tag = 33'h1_FFFF_FFFF; wr_asn = 8'hFF; wr_perm = 4'hF;
      wr_valid = 1'b0; cyc("R8");
      wr_phys = 1'b1; cyc("R8");

      // random mix, mostly near-matching entries
      for (int i = 0; i < 3000; i++) begin
         lk_vaddr = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
         lk_asn = 8'($urandom); lk_mode = 2'($urandom); lk_phys = 1'($urandom);
         good_entry();
         ent_glob = 1'($urandom);
         ent_perm = 4'($urandom);
         fix_par();
         if ($urandom % 5 == 0) ent_asn = 8'($urandom);
         if ($urandom % 7 == 0) ent_tag = ent_tag ^ (33'h1 << ($urandom % 33));
         if ($urandom % 8 == 0) ent_phys = ~ent_phys;
         if ($urandom % 9 == 0) ent_valid = 1'b0;
         if ($urandom % 6 == 0) ent_par = ~ent_par;
         wr_en = 1'($urandom); wr_valid = 1'($urandom);
         wr_tag = {1'($urandom), 32'($urandom)}; wr_asn = 8'($urandom);
         wr_glob = 1'($urandom); wr_phys = 1'($urandom); wr_perm = 4'($urandom);
         cyc("R1");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule